// File: doc/BRIEF.md
# Instrument Status Byte and Service Request Core

This block collects the status of a programmable instrument into an 8-bit status byte and raises a service request line toward the controller. Two 16-bit event groups, one for questionable conditions and one for operational conditions, watch their condition inputs every clock. Each group records selected rising and falling edges in a sticky event register. An enable mask reduces each group to a single summary bit. A third summary bit comes in directly from a standard-event stage. The core also keeps an outbound message FIFO, and its non-empty flag forms the message-available bit.

Bit 6 of the status byte reads differently depending on the kind of read. With `serial_poll` low, `stb_rdata` is a plain query: bit 6 shows the live master summary and no state changes. With `serial_poll` high, bit 6 shows the latched request bit, and that bit alone is cleared at the clock edge. The request bit latches when the master summary rises, and `srq` follows it. Filter and mask registers are loaded through a small address/data write port. Each event register is read from its own output and cleared by a one-cycle strobe.

Top module: `stb_core`

## Requirements
- R1: The status byte is laid out as follows: bit 3 questionable summary, bit 4 message available, bit 5 standard event input, bit 7 operation summary, bits 0 to 2 always zero. With `serial_poll` low, bit 6 of `stb_rdata` is the live OR of bits 3, 4, 5 and 7 that are also set in the request enable mask. Bit 6 of that mask is ignored.
- R2: A query (reading `stb_rdata` with `serial_poll` low) changes no state: `srq` and every status bit keep their values.
- R3: The request bit sets on the clock edge after the master summary goes from 0 to 1, and `srq` equals the request bit. While the master summary stays high, no new request is raised.
- R4: With `serial_poll` high, bit 6 of `stb_rdata` returns the request bit. The following edge clears the request bit and no other status bit.
- R5: Bit 4 is high exactly while the message FIFO holds at least one byte.
- R6: A clear strobe (`rd_ques_clr`, `rd_oper_clr`) empties that group's event register at the next edge, and the group's summary bit drops with it. A transition latched in the same cycle as the clear survives.
- R7: An event bit sets when its condition rises and its positive filter bit is 1, or when its condition falls and its negative filter bit is 1. Event bits stay set until cleared.
- R8: A group summary is the OR of its event bits ANDed with its enable mask. Clearing a request enable bit removes that bit's contribution to the master summary.
- R9: The FIFO keeps 16 bytes in arrival order. A push while full is dropped, and `msg_ovf` pulses high for the one cycle after it.
- R10: `msg_pop_data` shows the oldest byte. When the FIFO is empty it reads zero, and a pop has no effect.
- R11: Write address map: 0 questionable positive filter, 1 questionable negative filter, 2 questionable enable, 3 operation positive filter, 4 operation negative filter, 5 operation enable, 6 request enable (low 8 data bits). Reset values: positive filters all ones, and all other masks zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ques_cond | input | 16 | Questionable condition inputs |
| oper_cond | input | 16 | Operation condition inputs |
| std_evt_sum | input | 1 | Standard event summary, placed on bit 5 |
| wr_en | input | 1 | Mask/filter write strobe |
| wr_addr | input | 3 | Write target (see R11) |
| wr_data | input | 16 | Write data |
| rd_ques_clr | input | 1 | Clear questionable event register |
| rd_oper_clr | input | 1 | Clear operation event register |
| ques_event | output | 16 | Questionable event register contents |
| oper_event | output | 16 | Operation event register contents |
| serial_poll | input | 1 | Serial poll access strobe |
| stb_rdata | output | 8 | Status byte read value |
| srq | output | 1 | Service request line |
| msg_push | input | 1 | Push a byte into the message FIFO |
| msg_push_data | input | 8 | Byte to push |
| msg_pop | input | 1 | Pop the oldest byte |
| msg_pop_data | output | 8 | Oldest byte, zero when empty |
| msg_ovf | output | 1 | One-cycle pulse after a dropped push |

## Verification
A clear strobe on an event register can land in the same cycle as a new condition transition on that group. The bench provokes this by asserting `rd_ques_clr` while a questionable condition bit rises. It judges the outcome by requiring the register to hold only the fresh bit afterwards. A serial poll can also coincide with a still-high master summary. In that case bit 6 must read the latched request value while the live summary stays visible in the query view one cycle later.

// File: rtl/stb_pkg.sv
package stb_pkg;
   localparam int QUES_BIT = 3;
   localparam int MAV_BIT  = 4;
   localparam int STD_BIT  = 5;
   localparam int MSS_BIT  = 6;
   localparam int OPER_BIT = 7;
   localparam int STB_W    = 8;

   typedef enum logic [2:0] {
      ADR_QPTR = 3'd0,
      ADR_QNTR = 3'd1,
      ADR_QENA = 3'd2,
      ADR_OPTR = 3'd3,
      ADR_ONTR = 3'd4,
      ADR_OENA = 3'd5,
      ADR_SRE  = 3'd6
   } stb_adr_e;
endpackage

// File: rtl/stb_evt_group.sv
module stb_evt_group #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cond,
   input  logic         wr_ptr,
   input  logic         wr_ntr,
   input  logic         wr_ena,
   input  logic [W-1:0] wr_data,
   input  logic         clr,
   output logic [W-1:0] evt,
   output logic         summary
);
   logic [W-1:0] prev, ptr, ntr, ena, set_bits;

   if (W < 1) begin : g_bad_w
      $error("stb_evt_group: W must be at least 1");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      assign set_bits[b] = (cond[b] & ~prev[b] & ptr[b]) |
                           (~cond[b] & prev[b] & ntr[b]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev <= '0;
         ptr  <= '1;
         ntr  <= '0;
         ena  <= '0;
         evt  <= '0;
      end else begin
         prev <= cond;
         if (wr_ptr) ptr <= wr_data;
         if (wr_ntr) ntr <= wr_data;
         if (wr_ena) ena <= wr_data;
         evt <= (clr ? '0 : evt) | set_bits;
      end
   end

   assign summary = |(evt & ena);

   // R6: a clear with no fresh transition empties the register
   a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && set_bits == '0) |=> evt == '0);
   // R7: a filtered transition is latched at the next edge
   a_r7_latch_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_bits) |=> ((evt & $past(set_bits)) == $past(set_bits)));
   // R7: without a clear, event bits are sticky
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((evt & $past(evt)) == $past(evt)));
endmodule

// File: rtl/stb_msg_fifo.sv
module stb_msg_fifo #(
   parameter int DEPTH = 16,
   parameter int DW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [DW-1:0] pop_data,
   output logic          not_empty,
   output logic          ovf
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [AW:0] CNT_FULL = (AW + 1)'(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("stb_msg_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          full, push_ok, pop_ok;

   assign full      = (cnt == CNT_FULL);
   assign not_empty = (cnt != '0);
   assign push_ok   = push && !full;
   assign pop_ok    = pop && not_empty;
   assign pop_data  = not_empty ? mem[rp] : '0;

   always_ff @(posedge clk) begin
      if (push_ok) mem[wp] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
         ovf <= 1'b0;
      end else begin
         if (push_ok) wp <= wp + 1'b1;
         if (pop_ok)  rp <= rp + 1'b1;
         cnt <= cnt + (AW + 1)'(push_ok) - (AW + 1)'(pop_ok);
         ovf <= push && full;
      end
   end

   // R9: a push into a full queue is dropped and flagged
   a_r9_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (ovf && cnt == CNT_FULL));
   // R5: a push into an empty queue makes it non-empty
   a_r5_push_fills: assert property (@(posedge clk) disable iff (!rst_n)
      (!not_empty && push) |=> not_empty);
   // R10: a pop on an empty queue leaves it empty
   a_r10_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (!not_empty && pop && !push) |=> !not_empty);
endmodule

// File: rtl/stb_srq_latch.sv
module stb_srq_latch import stb_pkg::*; (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [STB_W-1:0] stb_bits,
   input  logic [STB_W-1:0] sre,
   input  logic             poll,
   output logic             mss,
   output logic             rqs
);
   logic mss_q, mss_rise;

   assign mss      = |(stb_bits & sre & ~(STB_W'(1) << MSS_BIT));
   assign mss_rise = mss && !mss_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mss_q <= 1'b0;
         rqs   <= 1'b0;
      end else begin
         mss_q <= mss;
         if (mss_rise)  rqs <= 1'b1;
         else if (poll) rqs <= 1'b0;
      end
   end

   // R3: a rising master summary latches a request
   a_r3_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
      mss_rise |=> rqs);
   // R3: no request appears without a rising master summary
   a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (!rqs && !mss_rise) |=> !rqs);
   // R4: a serial poll clears the latched request
   a_r4_poll_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (poll && !mss_rise) |=> !rqs);
endmodule

// File: rtl/stb_core.sv
module stb_core import stb_pkg::*; #(
   parameter int EVT_W      = 16,
   parameter int FIFO_DEPTH = 16,
   parameter int MSG_W      = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] ques_cond,
   input  logic [EVT_W-1:0] oper_cond,
   input  logic             std_evt_sum,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [EVT_W-1:0] wr_data,
   input  logic             rd_ques_clr,
   input  logic             rd_oper_clr,
   output logic [EVT_W-1:0] ques_event,
   output logic [EVT_W-1:0] oper_event,
   input  logic             serial_poll,
   output logic [7:0]       stb_rdata,
   output logic             srq,
   input  logic             msg_push,
   input  logic [MSG_W-1:0] msg_push_data,
   input  logic             msg_pop,
   output logic [MSG_W-1:0] msg_pop_data,
   output logic             msg_ovf
);
   if (EVT_W < STB_W) begin : g_bad_evt_w
      $error("stb_core: EVT_W must cover the request enable width");
   end

   logic             ques_sum, oper_sum, mav, mss, rqs;
   logic [STB_W-1:0] sre, stb_bits;

   stb_evt_group #(.W(EVT_W)) i_ques (
      .clk(clk), .rst_n(rst_n), .cond(ques_cond),
      .wr_ptr(wr_en && wr_addr == ADR_QPTR),
      .wr_ntr(wr_en && wr_addr == ADR_QNTR),
      .wr_ena(wr_en && wr_addr == ADR_QENA),
      .wr_data(wr_data), .clr(rd_ques_clr),
      .evt(ques_event), .summary(ques_sum));

   stb_evt_group #(.W(EVT_W)) i_oper (
      .clk(clk), .rst_n(rst_n), .cond(oper_cond),
      .wr_ptr(wr_en && wr_addr == ADR_OPTR),
      .wr_ntr(wr_en && wr_addr == ADR_ONTR),
      .wr_ena(wr_en && wr_addr == ADR_OENA),
      .wr_data(wr_data), .clr(rd_oper_clr),
      .evt(oper_event), .summary(oper_sum));

   stb_msg_fifo #(.DEPTH(FIFO_DEPTH), .DW(MSG_W)) i_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(msg_push), .push_data(msg_push_data),
      .pop(msg_pop), .pop_data(msg_pop_data),
      .not_empty(mav), .ovf(msg_ovf));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          sre <= '0;
      else if (wr_en && wr_addr == ADR_SRE) sre <= wr_data[STB_W-1:0];
   end

   always_comb begin
      stb_bits           = '0;
      stb_bits[QUES_BIT] = ques_sum;
      stb_bits[MAV_BIT]  = mav;
      stb_bits[STD_BIT]  = std_evt_sum;
      stb_bits[OPER_BIT] = oper_sum;
   end

   stb_srq_latch i_srq (
      .clk(clk), .rst_n(rst_n), .stb_bits(stb_bits), .sre(sre),
      .poll(serial_poll), .mss(mss), .rqs(rqs));

   always_comb begin
      stb_rdata          = stb_bits;
      stb_rdata[MSS_BIT] = serial_poll ? rqs : mss;
   end

   assign srq = rqs;

   // R2: a cycle with neither poll nor rising summary keeps the request
   a_r2_query_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (!serial_poll && srq) |=> srq);
   // R1: bits 0 to 2 of the status byte are always zero
   a_r1_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      stb_rdata[2:0] == 3'b000);
endmodule

// File: tb/test_stb_core.sv
module test_stb_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ques_cond = '0, oper_cond = '0, wr_data = '0;
   logic        std_evt_sum = 1'b0, wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic        rd_ques_clr = 1'b0, rd_oper_clr = 1'b0, serial_poll = 1'b0;
   logic        msg_push = 1'b0, msg_pop = 1'b0;
   logic [7:0]  msg_push_data = '0;
   logic [15:0] ques_event, oper_event;
   logic [7:0]  stb_rdata, msg_pop_data;
   logic        srq, msg_ovf;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   stb_core i_stb_core (
      .clk(clk), .rst_n(rst_n), .ques_cond(ques_cond), .oper_cond(oper_cond),
      .std_evt_sum(std_evt_sum), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_ques_clr(rd_ques_clr), .rd_oper_clr(rd_oper_clr),
      .ques_event(ques_event), .oper_event(oper_event),
      .serial_poll(serial_poll), .stb_rdata(stb_rdata), .srq(srq),
      .msg_push(msg_push), .msg_push_data(msg_push_data), .msg_pop(msg_pop),
      .msg_pop_data(msg_pop_data), .msg_ovf(msg_ovf));

   typedef struct packed {
      logic [15:0] cond;
      logic        clr;
      logic [15:0] exp;
   } vec_t;

   // questionable group, positive filter all ones, negative filter 0x00F0
   localparam vec_t VECS [8] = '{
      '{16'h0001, 1'b0, 16'h0001},
      '{16'h0011, 1'b0, 16'h0011},
      '{16'h0001, 1'b0, 16'h0011},
      '{16'h0000, 1'b1, 16'h0000},
      '{16'h8100, 1'b0, 16'h8100},
      '{16'h8100, 1'b1, 16'h0000},
      '{16'h0080, 1'b1, 16'h0080},
      '{16'h0000, 1'b0, 16'h0080}
   };

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      tick();
      // reset state
      check("R11 reset stb", {8'h0, stb_rdata}, 16'h0000);
      check("R3 reset srq", {15'h0, srq}, 16'h0000);
      check("R10 reset pop", {8'h0, msg_pop_data}, 16'h0000);
      check("R6 reset ques", ques_event, 16'h0000);
      check("R9 reset ovf", {15'h0, msg_ovf}, 16'h0000);

      // R11: negative filter at address 1
      wr(3'd1, 16'h00F0);
      foreach (VECS[i]) begin
         ques_cond   = VECS[i].cond;
         rd_ques_clr = VECS[i].clr;
         tick();
         check("R7 R6 vector", ques_event, VECS[i].exp);
      end
      rd_ques_clr = 1'b0;

      // service request path
      wr(3'd5, 16'h0002);
      wr(3'd6, 16'h0080);
      oper_cond = 16'h0002;
      tick();
      check("R1 query mss", {8'h0, stb_rdata}, 16'h00C0);
      check("R3 not yet", {15'h0, srq}, 16'h0000);
      tick();
      check("R3 srq set", {15'h0, srq}, 16'h0001);
      tick();
      check("R2 query keeps srq", {15'h0, srq}, 16'h0001);
      check("R2 query keeps stb", {8'h0, stb_rdata}, 16'h00C0);
      serial_poll = 1'b1;
      #1 check("R4 poll returns rqs", {8'h0, stb_rdata}, 16'h00C0);
      tick();
      serial_poll = 1'b0;
      #1 check("R4 rqs cleared", {15'h0, srq}, 16'h0000);
      check("R4 others kept", {8'h0, stb_rdata}, 16'h00C0);
      repeat (3) tick();
      check("R3 no re-request", {15'h0, srq}, 16'h0000);
      serial_poll = 1'b1;
      #1 check("R4 poll bit6 low", {8'h0, stb_rdata}, 16'h0080);
      tick();
      serial_poll = 1'b0;

      // enable mask
      wr(3'd6, 16'h0040);
      check("R1 mask bit6 ignored", {8'h0, stb_rdata}, 16'h0080);
      check("R8 srq off", {15'h0, srq}, 16'h0000);
      wr(3'd6, 16'h0080);
      tick();
      check("R8 re-enable request", {15'h0, srq}, 16'h0001);

      // event read and clear
      rd_oper_clr = 1'b1;
      #1 check("R6 read value", oper_event, 16'h0002);
      tick();
      rd_oper_clr = 1'b0;
      #1 check("R6 cleared", oper_event, 16'h0000);
      check("R6 summary drop", {8'h0, stb_rdata}, 16'h0000);
      serial_poll = 1'b1;
      tick();
      serial_poll = 1'b0;

      // filters on the operation group
      wr(3'd3, 16'h0000);
      wr(3'd4, 16'h0008);
      oper_cond = 16'h000A;
      tick();
      check("R7 R11 rise blocked", oper_event, 16'h0000);
      oper_cond = 16'h0002;
      tick();
      check("R7 R11 fall latched", oper_event, 16'h0008);

      // standard event input
      std_evt_sum = 1'b1;
      #1 check("R1 std bit", {8'h0, stb_rdata}, 16'h0020);
      std_evt_sum = 1'b0;

      // message queue
      msg_push = 1'b1; msg_push_data = 8'hA5;
      tick();
      msg_push = 1'b0;
      check("R5 mav set", {8'h0, stb_rdata}, 16'h0010);
      check("R10 head", {8'h0, msg_pop_data}, 16'h00A5);
      msg_pop = 1'b1;
      tick();
      msg_pop = 1'b0;
      check("R5 mav clear", {8'h0, stb_rdata}, 16'h0000);
      check("R10 empty zero", {8'h0, msg_pop_data}, 16'h0000);
      msg_pop = 1'b1;
      tick();
      msg_pop = 1'b0;
      check("R10 pop empty", {8'h0, msg_pop_data}, 16'h0000);
      check("R10 pop empty mav", {8'h0, stb_rdata}, 16'h0000);

      for (int i = 0; i < 16; i++) begin
         msg_push = 1'b1; msg_push_data = 8'(i * 3 + 1);
         tick();
      end
      msg_push_data = 8'hEE;
      tick();
      msg_push = 1'b0;
      check("R9 overflow pulse", {15'h0, msg_ovf}, 16'h0001);
      tick();
      check("R9 overflow ends", {15'h0, msg_ovf}, 16'h0000);
      for (int i = 0; i < 16; i++) begin
         check("R9 order", {8'h0, msg_pop_data}, 16'(8'(i * 3 + 1)));
         msg_pop = 1'b1;
         tick();
      end
      msg_pop = 1'b0;
      check("R9 drained", {8'h0, msg_pop_data}, 16'h0000);
      check("R5 drained mav", {8'h0, stb_rdata}, 16'h0000);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule